// File: doc/BRIEF.md
# Configuration Bus Enumeration Scanner

This block is a hardware sequencer that finds out which devices sit on a configuration bus hierarchy. After a start pulse it visits every bus and device number. For each one it issues a configuration read of the identity dword, which is register 0 of function 0. It uses the same request and response handshake that a configuration access bridge takes. A device whose memory space has not yet been enabled cannot be reached any other way, so the scanner uses only configuration reads.

An aborted read comes back as all ones. The scanner therefore treats a vendor field of 0xFFFF as an empty slot. For every slot it keeps one presence bit. For each occupied slot it also keeps the full 32-bit identity word, which a read port returns. When the last probe has completed, a one-cycle done pulse marks the presence bitmap and the device count as final. Bridge recursion, functions other than zero and the setup of devices are handled elsewhere.

Top module: `cfg_enum_scanner`

## Requirements
- R1: Each probe asserts `req_valid_o` with `req_func_o` = 0 and `req_reg_o` = 0. `req_valid_o`, `req_bus_o` and `req_dev_o` then hold steady until the cycle in which `req_ready_i` is also high.
- R2: Probes cover device 0 to 31 of bus 0, then the same devices on bus 1, and so on up to `MAX_BUS`. Device is the fastest-changing index. Each slot is probed exactly once, and a new request is only raised after the response to the previous one has arrived.
- R3: When the response data has bits 15:0 not equal to 0xFFFF, the presence bit at index bus*32+device is set. When bits 15:0 equal 0xFFFF, the slot is empty whatever bits 31:16 hold.
- R4: `rd_id_o` returns the full 32-bit identity word of slot `rd_slot_i` when that slot is present. It returns 0 when the slot is absent.
- R5: A start pulse while idle clears the presence bitmap and the count, and begins a scan. `busy_o` is high from the next cycle.
- R6: A start pulse that arrives while a scan is running has no effect on the probe sequence or on the results.
- R7: `done_o` is high for exactly one cycle, the cycle after the final response is taken. `busy_o` is still high in that cycle and low in the cycle after it.
- R8: `dev_count_o` equals the number of present slots when `done_o` is high.
- R9: After reset, `busy_o`, `done_o` and `req_valid_o` are low, the presence bitmap is all zero and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (honoured only when idle) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when the scan is complete |
| req_valid_o | output | 1 | Configuration read request valid |
| req_ready_i | input | 1 | Bridge accepts the request |
| req_bus_o | output | BUS_W | Bus number of the probe |
| req_dev_o | output | 5 | Device number of the probe |
| req_func_o | output | 3 | Function number (always 0) |
| req_reg_o | output | 6 | Dword register index (always 0) |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 32 | Read data: device ID in 31:16, vendor ID in 15:0 |
| rd_slot_i | input | SLOT_W | Slot index (bus*32+device) to read back |
| rd_id_o | output | 32 | Identity word of the selected slot, 0 if absent |
| present_o | output | NUM_SLOTS | Presence bitmap indexed by slot |
| dev_count_o | output | CNT_W | Number of devices found |

## Verification
Acceptance of a request takes effect at the edge where `req_valid_o` and `req_ready_i` are both high. A response is taken at the edge where `rsp_valid_i` is high during the wait state. Its presence bit, identity word and count change at that same edge, so they are visible in the following cycle. `done_o` rises one cycle after the final response edge. The bench drives every input and samples every output on the falling clock edge, so each result is read half a cycle after the rising edge that produced it. The bench's responder varies the accept stall and the response latency from slot to slot. It also checks the order of the requests and the stability of a held request as each one arrives.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;
  localparam int unsigned DEV_PER_BUS = 32;
  localparam int unsigned DEV_W       = 5;
  localparam int unsigned FUNC_W      = 3;
  localparam int unsigned REG_W       = 6;
  localparam logic [15:0] VENDOR_NONE = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } scan_state_e;
endpackage

// File: rtl/cfg_scan_ctrl.sv
module cfg_scan_ctrl
  import cfg_scan_pkg::*;
#(
  parameter int unsigned MAX_BUS   = 3,
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned NUM_SLOTS = (MAX_BUS + 1) * DEV_PER_BUS,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  output logic              req_valid_o,
  output logic [BUS_W-1:0]  req_bus_o,
  output logic [DEV_W-1:0]  req_dev_o,
  output logic              clear_o,
  output logic              rec_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  scan_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic              last_w;

  assign last_w  = (slot_q == LAST_SLOT);
  assign clear_o = (state_q == ST_IDLE) && start_i;
  assign rec_o   = (state_q == ST_WAIT) && rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) state_d = last_w ? ST_DONE : ST_REQ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      if (clear_o)                slot_q <= '0;
      else if (rec_o && !last_w)  slot_q <= slot_q + 1'b1;
    end
  end

  // slot index is bus*32+dev; dev is the low five bits
  assign req_dev_o   = slot_q[DEV_W-1:0];
  assign req_bus_o   = BUS_W'(slot_q >> DEV_W);
  assign req_valid_o = (state_q == ST_REQ);
  assign slot_o      = slot_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(slot_q));

  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o && !last_w |=> slot_q == $past(slot_q) + 1'b1);

  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i |=> busy_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: rtl/cfg_id_store.sv
module cfg_id_store
  import cfg_scan_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 128,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  parameter int unsigned CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 wr_i,
  input  logic [SLOT_W-1:0]    wr_slot_i,
  input  logic [31:0]          wr_data_i,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  output logic [31:0]          rd_id_o,
  output logic [NUM_SLOTS-1:0] present_o,
  output logic [CNT_W-1:0]     count_o
);
  logic [NUM_SLOTS-1:0] present_q;
  logic [CNT_W-1:0]     count_q;
  logic [31:0]          id_mem [NUM_SLOTS];
  logic                 hit_w;
  logic                 rd_ok_w;

  assign hit_w   = wr_i && (wr_data_i[15:0] != VENDOR_NONE);
  assign rd_ok_w = (int'(rd_slot_i) < NUM_SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= '0;
      count_q   <= '0;
    end else if (clear_i) begin
      present_q <= '0;
      count_q   <= '0;
    end else if (wr_i) begin
      present_q[wr_slot_i] <= hit_w;
      if (hit_w) count_q <= count_q + 1'b1;
    end
  end

  // identity words are gated by the presence bit, so no reset is needed
  always_ff @(posedge clk_i) begin
    if (hit_w) id_mem[wr_slot_i] <= wr_data_i;
  end

  assign rd_id_o   = (rd_ok_w && present_q[rd_slot_i]) ? id_mem[rd_slot_i] : '0;
  assign present_o = present_q;
  assign count_o   = count_q;

  a_r3_empty_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clear_i && wr_data_i[15:0] == VENDOR_NONE |=> !present_q[$past(wr_slot_i)]);

  a_r3_found_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clear_i && wr_data_i[15:0] != VENDOR_NONE |=> present_q[$past(wr_slot_i)]);

  a_r8_count_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> count_q >= $past(count_q));

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= NUM_SLOTS);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_q == '0 && present_q == '0);
endmodule

// File: rtl/cfg_enum_scanner.sv
module cfg_enum_scanner
  import cfg_scan_pkg::*;
#(
  parameter int unsigned MAX_BUS   = 3,
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned NUM_SLOTS = (MAX_BUS + 1) * DEV_PER_BUS,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  parameter int unsigned CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [BUS_W-1:0]     req_bus_o,
  output logic [DEV_W-1:0]     req_dev_o,
  output logic [FUNC_W-1:0]    req_func_o,
  output logic [REG_W-1:0]     req_reg_o,
  input  logic                 rsp_valid_i,
  input  logic [31:0]          rsp_data_i,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  output logic [31:0]          rd_id_o,
  output logic [NUM_SLOTS-1:0] present_o,
  output logic [CNT_W-1:0]     dev_count_o
);
  logic              clear_w;
  logic              rec_w;
  logic [SLOT_W-1:0] slot_w;

  // identity dword of function 0 only
  assign req_func_o = '0;
  assign req_reg_o  = '0;

  cfg_scan_ctrl #(
    .MAX_BUS  (MAX_BUS),
    .BUS_W    (BUS_W),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .req_valid_o(req_valid_o),
    .req_bus_o  (req_bus_o),
    .req_dev_o  (req_dev_o),
    .clear_o    (clear_w),
    .rec_o      (rec_w),
    .slot_o     (slot_w),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  cfg_id_store #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .CNT_W    (CNT_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_w),
    .wr_i     (rec_w),
    .wr_slot_i(slot_w),
    .wr_data_i(rsp_data_i),
    .rd_slot_i(rd_slot_i),
    .rd_id_o  (rd_id_o),
    .present_o(present_o),
    .count_o  (dev_count_o)
  );

  a_r8_count_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> int'(dev_count_o) == $countones(present_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o && !done_o);
endmodule

// File: tb/tb_cfg_enum_scanner.sv
module tb_cfg_enum_scanner;
  localparam int NSLOT = 128;
  localparam int NVEC  = 6;
  // [40:33] slot, [32:1] identity word, [0] expected presence
  localparam logic [40:0] VEC [NVEC] = '{
    {8'd0,   32'h1234_8086, 1'b1},
    {8'd7,   32'hABCD_10EC, 1'b1},
    {8'd31,  32'h0001_FFFE, 1'b1},
    {8'd32,  32'h5678_FFFF, 1'b0},
    {8'd65,  32'hDEAD_1AF4, 1'b1},
    {8'd127, 32'h0000_0000, 1'b1}
  };

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        start_i = 0;
  logic        req_ready_i = 0;
  logic        rsp_valid_i = 0;
  logic [31:0] rsp_data_i = '0;
  logic [6:0]  rd_slot_i = '0;
  logic        busy_o, done_o, req_valid_o;
  logic [7:0]  req_bus_o;
  logic [4:0]  req_dev_o;
  logic [2:0]  req_func_o;
  logic [5:0]  req_reg_o;
  logic [31:0] rd_id_o;
  logic [NSLOT-1:0] present_o;
  logic [7:0]  dev_count_o;

  int total = 0, bad = 0;
  int exp_slot = 0, probes = 0, ord_err = 0, fr_err = 0, hold_err = 0, done_cnt = 0;
  bit alt_mode = 0, finished = 0;

  always #2 clk = ~clk;

  cfg_enum_scanner dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_bus_o(req_bus_o),
    .req_dev_o(req_dev_o), .req_func_o(req_func_o), .req_reg_o(req_reg_o),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rd_slot_i(rd_slot_i),
    .rd_id_o(rd_id_o), .present_o(present_o), .dev_count_o(dev_count_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input int s);
    if (alt_mode) return (s == 65) ? 32'hDEAD_1AF4 : 32'hFFFF_FFFF;
    for (int i = 0; i < NVEC; i++)
      if (int'(VEC[i][40:33]) == s) return VEC[i][32:1];
    return 32'hFFFF_FFFF;
  endfunction

  // bridge model: stall every slot with s%4==1, response latency s%3
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && req_valid_o) begin
        automatic int s = int'(req_bus_o) * 32 + int'(req_dev_o);
        automatic logic [7:0] b = req_bus_o;
        automatic logic [4:0] d = req_dev_o;
        if (s != exp_slot) ord_err++;
        if (req_func_o != 0 || req_reg_o != 0) fr_err++;
        exp_slot++;
        probes++;
        if (s % 4 == 1) begin
          @(negedge clk);
          if (!req_valid_o || req_bus_o != b || req_dev_o != d) hold_err++;
        end
        req_ready_i = 1;
        @(negedge clk);
        req_ready_i = 0;
        repeat (s % 3) @(negedge clk);
        rsp_valid_i = 1;
        rsp_data_i  = lookup(s);
        @(negedge clk);
        rsp_valid_i = 0;
        rsp_data_i  = '0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_o) done_cnt++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=scan complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_scan(input int mid_start);
    exp_slot = 0; probes = 0; ord_err = 0; fr_err = 0; hold_err = 0; done_cnt = 0;
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R5 busy after start", 32'(busy_o), 32'd1);
    chk("R5 bitmap cleared", 32'($countones(present_o)), 32'd0);
    if (mid_start > 0) begin
      repeat (mid_start) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (!done_o) @(negedge clk);
    chk("R7 busy during done", 32'(busy_o), 32'd1);
    chk("R8 count vs bitmap", 32'(dev_count_o), 32'($countones(present_o)));
    @(negedge clk);
    chk("R7 done low after pulse", 32'(done_o), 32'd0);
    chk("R7 busy low after done", 32'(busy_o), 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 single done pulse", 32'(done_cnt), 32'd1);
    chk("R2 probe order", 32'(ord_err), 32'd0);
    chk("R2 probe count", 32'(probes), 32'(NSLOT));
    chk("R1 func and reg zero", 32'(fr_err), 32'd0);
    chk("R1 held request stable", 32'(hold_err), 32'd0);
  endtask

  initial begin
    automatic int exp_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R9 busy", 32'(busy_o), 32'd0);
    chk("R9 done", 32'(done_o), 32'd0);
    chk("R9 req_valid", 32'(req_valid_o), 32'd0);
    chk("R9 bitmap", 32'($countones(present_o)), 32'd0);
    chk("R9 count", 32'(dev_count_o), 32'd0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // scan 1: table-driven population
    run_scan(0);
    for (int i = 0; i < NVEC; i++) begin
      rd_slot_i = VEC[i][39:33];
      #1;
      chk($sformatf("R3 presence slot %0d", VEC[i][40:33]), 32'(present_o[VEC[i][39:33]]), 32'(VEC[i][0]));
      chk($sformatf("R4 identity slot %0d", VEC[i][40:33]), rd_id_o, VEC[i][0] ? VEC[i][32:1] : 32'd0);
      exp_cnt += int'(VEC[i][0]);
    end
    chk("R8 count scan 1", 32'(dev_count_o), 32'(exp_cnt));
    rd_slot_i = 7'd50;
    #1;
    chk("R4 absent slot reads zero", rd_id_o, 32'd0);

    // scan 2: only slot 65 answers; start pulsed mid-scan must be ignored
    alt_mode = 1;
    run_scan(40);
    chk("R6 count with mid-scan start", 32'(dev_count_o), 32'd1);
    rd_slot_i = 7'd0;
    #1;
    chk("R5 stale slot 0 cleared", 32'(present_o[0]), 32'd0);
    chk("R5 stale id 0 reads zero", rd_id_o, 32'd0);
    rd_slot_i = 7'd65;
    #1;
    chk("R4 slot 65 after rescan", rd_id_o, 32'hDEAD_1AF4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule